// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block turns 16-bit push and pop requests from a processor core into pairs of byte transfers on a byte-wide memory. It holds a 16-bit stack offset register and a 16-bit segment register. For every byte access it builds a 20-bit physical address from them: the segment shifted left by four bits, plus the byte offset, with the sum wrapping modulo 2^20. A push places the upper byte just below the current offset and the lower byte two below it, then moves the offset down by two. A pop reads the same two locations back, taking them relative to the offset plus two, then moves the offset up by two. A pop therefore undoes the push before it exactly. The offset wraps modulo 2^16 with no fault of any kind.

On the core side, `ready` acts as back-pressure. A request is taken only on a clock edge where `ready` is high, and `ready` stays low until the operation is done. Requests raised while `ready` is low are dropped, not queued, so the core must hold or repeat them. A taken request runs in a fixed sequence: one cycle for the upper byte, one cycle for the lower byte, then a one-cycle `ack`, during which a popped word is on `pop_data`. The offset and segment registers can be loaded directly while the engine is idle. The memory side has no back-pressure: it must complete a write in the cycle it is enabled, and it must return read data within that same cycle.

Top module: `wstk_top`

## Requirements
- R1: After reset, the offset and segment registers are both 0, `ready` is 1, `ack` and `err` are 0, and `mem_en` is 0.
- R2: A request is taken only on an edge where `ready` is 1. `ready` is 0 from the next cycle through the `ack` cycle. A request raised while `ready` is 0 is ignored and does not start a further operation.
- R3: A push writes the upper data byte (bits 15:8) in the first cycle after acceptance, at offset SP-1. It writes the lower byte (bits 7:0) in the second cycle, at offset SP-2. In both cycles `mem_en`=1 and `mem_we`=1.
- R4: After a push, `sp_out` equals the old offset minus 2. The new value is visible from the `ack` cycle onward.
- R5: A pop reads the upper byte at offset SP+1 in the first cycle and the lower byte at offset SP in the second cycle, with `mem_we`=0. In the `ack` cycle `pop_data` holds {upper, lower}, and `sp_out` equals the old offset plus 2.
- R6: Each byte address is (segment × 16 + byte offset) modulo 2^20.
- R7: Byte offsets and the offset register wrap modulo 2^16.
- R8: `ack` is high for exactly one cycle, the third cycle after the accepting edge.
- R9: If push and pop are requested together, only the push is performed, and `err` is high for exactly one cycle, the first cycle after acceptance.
- R10: A load of the offset or segment register while `ready` is 1 takes effect at that edge and is used by a request taken at the same edge. A load while `ready` is 0 is ignored.
- R11: `mem_en` is 0 whenever no byte transfer is in progress, including the idle cycles and the `ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | 16 | Word to push, sampled at acceptance |
| sp_load | input | 1 | Load the offset register |
| sp_load_val | input | 16 | Value for the offset register |
| seg_load | input | 1 | Load the segment register |
| seg_load_val | input | 16 | Value for the segment register |
| ready | output | 1 | Engine idle; a request can be taken |
| ack | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Popped word, valid during `ack` |
| err | output | 1 | Pulse marking a simultaneous push and pop |
| sp_out | output | 16 | Current offset register |
| seg_out | output | 16 | Current segment register |
| mem_en | output | 1 | Byte access enable |
| mem_we | output | 1 | Byte write (1) or read (0) |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the enabled cycle |

## Verification
Several internal faults have visible effects. A wrong sequencer state shows within one cycle: `mem_en` is active outside the two transfer cycles, `ack` comes at the wrong place, or `ready` returns early. A wrong offset or segment register shows on `mem_addr` at the very next byte transfer and on `sp_out` in the `ack` cycle. A byte-order or capture fault shows only when the word is popped again, at the `ack` of that pop. The vectors therefore pair every push with a pop, and they place addresses at both wrap boundaries.

// File: rtl/wstk_pkg.sv
package wstk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_ACK  = 2'd3
  } wstk_state_t;
endpackage

// File: rtl/wstk_seq.sv
module wstk_seq
  import wstk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic        pop_req,
  output wstk_state_t state,
  output logic        op_push,
  output logic        err,
  output logic        accept
);
  assign accept = (state == ST_IDLE) && (push_req || pop_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_push <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_HI;
          op_push <= push_req;            // push wins on conflict
          err     <= push_req && pop_req;
        end
        ST_HI:   state <= ST_LO;
        ST_LO:   state <= ST_ACK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: error flag never stretches past one cycle
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R8: byte phases follow each other without gaps
  p_hi_then_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HI) |=> (state == ST_LO));
  p_lo_then_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LO) |=> (state == ST_ACK));
endmodule

// File: rtl/wstk_regs.sv
module wstk_regs #(
  parameter int OFF_W = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             sp_ld,
  input  logic [OFF_W-1:0] sp_val,
  input  logic             seg_ld,
  input  logic [OFF_W-1:0] seg_val,
  input  logic             step,
  input  logic             dir_push,
  output logic [OFF_W-1:0] sp,
  output logic [OFF_W-1:0] seg
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      seg <= '0;
    end else begin
      if (step)
        sp <= dir_push ? sp - STEP_V : sp + STEP_V;   // wraps modulo 2^OFF_W
      else if (idle && sp_ld)
        sp <= sp_val;
      if (idle && seg_ld)
        seg <= seg_val;
    end
  end

  // R10: registers hold while a transfer runs, except the final step
  p_busy_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !step) |=> $stable(sp));
  p_busy_seg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> $stable(seg));
endmodule

// File: rtl/wstk_agen.sv
module wstk_agen #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [OFF_W-1:0]           sp,
  input  logic [OFF_W-1:0]           seg,
  input  logic                       hi_phase,
  input  logic                       dir_push,
  output logic [OFF_W+SEG_SHIFT-1:0] addr
);
  localparam int PHYS_W = OFF_W + SEG_SHIFT;

  logic [OFF_W-1:0]  off;
  logic [PHYS_W-1:0] base;
  logic [PHYS_W-1:0] off_ext;

  always_comb begin
    // push: SP-1 then SP-2; pop: (SP+2)-1 then (SP+2)-2
    if (dir_push) off = hi_phase ? sp - OFF_W'(1) : sp - OFF_W'(2);
    else          off = hi_phase ? sp + OFF_W'(1) : sp;
  end

  assign base    = {seg, {SEG_SHIFT{1'b0}}};
  assign off_ext = {{SEG_SHIFT{1'b0}}, off};
  assign addr    = base + off_ext;   // wraps modulo 2^PHYS_W
endmodule

// File: rtl/wstk_top.sv
module wstk_top
  import wstk_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int WORD_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic                       pop_req,
  input  logic [WORD_W-1:0]          push_data,
  input  logic                       sp_load,
  input  logic [OFF_W-1:0]           sp_load_val,
  input  logic                       seg_load,
  input  logic [OFF_W-1:0]           seg_load_val,
  output logic                       ready,
  output logic                       ack,
  output logic [WORD_W-1:0]          pop_data,
  output logic                       err,
  output logic [OFF_W-1:0]           sp_out,
  output logic [OFF_W-1:0]           seg_out,
  output logic                       mem_en,
  output logic                       mem_we,
  output logic [OFF_W+SEG_SHIFT-1:0] mem_addr,
  output logic [WORD_W/2-1:0]        mem_wdata,
  input  logic [WORD_W/2-1:0]        mem_rdata
);
  localparam int BYTE_W = WORD_W / 2;

  wstk_state_t       state;
  logic              op_push;
  logic              accept;
  logic              hi_phase;
  logic [WORD_W-1:0] wbuf;
  logic [WORD_W-1:0] rbuf;

  wstk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .state(state), .op_push(op_push), .err(err), .accept(accept)
  );

  wstk_regs #(.OFF_W(OFF_W), .STEP(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .idle(state == ST_IDLE),
    .sp_ld(sp_load), .sp_val(sp_load_val),
    .seg_ld(seg_load), .seg_val(seg_load_val),
    .step(state == ST_LO), .dir_push(op_push),
    .sp(sp_out), .seg(seg_out)
  );

  wstk_agen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_agen (
    .sp(sp_out), .seg(seg_out), .hi_phase(hi_phase), .dir_push(op_push),
    .addr(mem_addr)
  );

  assign hi_phase  = (state == ST_HI);
  assign ready     = (state == ST_IDLE);
  assign ack       = (state == ST_ACK);
  assign mem_en    = (state == ST_HI) || (state == ST_LO);
  assign mem_we    = mem_en && op_push;
  assign mem_wdata = hi_phase ? wbuf[WORD_W-1:BYTE_W] : wbuf[BYTE_W-1:0];
  assign pop_data  = rbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf <= '0;
      rbuf <= '0;
    end else begin
      if (accept) wbuf <= push_data;
      if (mem_en && !op_push) begin
        if (hi_phase) rbuf[WORD_W-1:BYTE_W] <= mem_rdata;
        else          rbuf[BYTE_W-1:0]      <= mem_rdata;
      end
    end
  end

  // R8: acknowledge is a single-cycle pulse followed by idle
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && ready));
  // R2: a taken request drops ready on the next cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (push_req || pop_req)) |=> !ready);
  // R11: no memory traffic in the cycle after acknowledge
  p_quiet_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !mem_en);
  // R9: error only right after an accepted transfer, which must be a write
  p_err_is_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (mem_en && mem_we));
endmodule

// File: tb/tb_wstk_top.sv
module tb_wstk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_req = 1'b0, pop_req = 1'b0;
  logic [15:0] push_data = '0;
  logic        sp_load = 1'b0, seg_load = 1'b0;
  logic [15:0] sp_load_val = '0, seg_load_val = '0;
  logic        ready, ack, err, mem_en, mem_we;
  logic [15:0] pop_data, sp_out, seg_out;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] mem [1024];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  wstk_top dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .sp_load(sp_load), .sp_load_val(sp_load_val),
    .seg_load(seg_load), .seg_load_val(seg_load_val), .ready(ready),
    .ack(ack), .pop_data(pop_data), .err(err), .sp_out(sp_out),
    .seg_out(seg_out), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[9:0]];
  always_ff @(posedge clk) if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        is_push;
    logic        ld;
    logic [15:0] seg;
    logic [15:0] sp;
    logic [15:0] data;
    logic [19:0] a_hi;
    logic [19:0] a_lo;
    logic [15:0] sp_after;
  } vec_t;

  // R3 R5 R6 R7: addresses = seg*16 + offset, both mod their widths
  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b1, 16'h1000, 16'h0100, 16'hA1B2, 20'h100FF, 20'h100FE, 16'h00FE},
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 16'hA1B2, 20'h100FF, 20'h100FE, 16'h0100},
    '{1'b1, 1'b1, 16'hFFFF, 16'h0012, 16'hC3D4, 20'h00001, 20'h00000, 16'h0010},
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 16'hC3D4, 20'h00001, 20'h00000, 16'h0012},
    '{1'b1, 1'b1, 16'h0200, 16'h0001, 16'h5566, 20'h02000, 20'h11FFF, 16'hFFFF},
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 16'h5566, 20'h02000, 20'h11FFF, 16'h0001}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1 && ack == 1'b0 && err == 1'b0 && mem_en == 1'b0, "R1 flags",
        {ready, ack, err, mem_en}, 4'b1000);
    chk(sp_out == 16'h0 && seg_out == 16'h0, "R1 regs", {sp_out, seg_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      // R10: idle loads apply at the accepting edge
      if (VEC[v].ld) begin
        seg_load = 1'b1; seg_load_val = VEC[v].seg;
        sp_load = 1'b1;  sp_load_val = VEC[v].sp;
      end
      push_req = VEC[v].is_push; pop_req = !VEC[v].is_push;
      push_data = VEC[v].is_push ? VEC[v].data : 16'h0;
      @(negedge clk);
      seg_load = 1'b0; sp_load = 1'b0; push_req = 1'b0; pop_req = 1'b0;
      if (VEC[v].ld)
        chk(seg_out == VEC[v].seg && sp_out == VEC[v].sp, "R10 idle load",
            {seg_out, sp_out}, {VEC[v].seg, VEC[v].sp});
      // upper byte phase
      chk(mem_en && mem_we == VEC[v].is_push && mem_addr == VEC[v].a_hi,
          "R3/R5/R6 hi addr", {11'd0, mem_we, mem_addr}, {11'd0, VEC[v].is_push, VEC[v].a_hi});
      if (VEC[v].is_push)
        chk(mem_wdata == VEC[v].data[15:8], "R3 hi byte", mem_wdata, VEC[v].data[15:8]);
      @(negedge clk);
      chk(mem_en && mem_we == VEC[v].is_push && mem_addr == VEC[v].a_lo,
          "R3/R5/R7 lo addr", {11'd0, mem_we, mem_addr}, {11'd0, VEC[v].is_push, VEC[v].a_lo});
      if (VEC[v].is_push)
        chk(mem_wdata == VEC[v].data[7:0], "R3 lo byte", mem_wdata, VEC[v].data[7:0]);
      @(negedge clk);
      chk(ack && !mem_en && !ready, "R8/R11 ack cycle", {ack, mem_en, ready}, 3'b100);
      chk(sp_out == VEC[v].sp_after, "R4/R5/R7 sp after", sp_out, VEC[v].sp_after);
      if (!VEC[v].is_push)
        chk(pop_data == VEC[v].data, "R5 pop data", pop_data, VEC[v].data);
      @(negedge clk);
      chk(!ack && ready, "R8 ack single", {ack, ready}, 2'b01);
    end

    // R9: push and pop together -> push, one-cycle err
    sp_load = 1'b1; sp_load_val = 16'h0040; seg_load = 1'b1; seg_load_val = 16'h0000;
    @(negedge clk);
    sp_load = 1'b0; seg_load = 1'b0;
    push_req = 1'b1; pop_req = 1'b1; push_data = 16'h9A7B;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    chk(err && mem_we && mem_addr == 20'h0003F, "R9 err+push", {err, mem_we, mem_addr}, {2'b11, 20'h0003F});
    // R10: load while busy ignored
    sp_load = 1'b1; sp_load_val = 16'h1234; seg_load = 1'b1; seg_load_val = 16'h4321;
    @(negedge clk);
    chk(!err, "R9 err one cycle", err, 1'b0);
    // R2: request while busy ignored
    pop_req = 1'b1;
    @(negedge clk);
    sp_load = 1'b0; seg_load = 1'b0; pop_req = 1'b0;
    chk(ack && sp_out == 16'h003E && seg_out == 16'h0000, "R10 busy load ignored",
        {sp_out, seg_out}, {16'h003E, 16'h0000});
    @(negedge clk);
    chk(ready && !mem_en, "R2 busy request dropped", {ready, mem_en}, 2'b10);
    @(negedge clk);
    chk(ready && !mem_en && !ack, "R11 idle quiet", {ready, mem_en, ack}, 3'b100);

    // R5: read back the conflict push
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(ack && pop_data == 16'h9A7B && sp_out == 16'h0040, "R5 pop after conflict",
        {pop_data, sp_out}, {16'h9A7B, 16'h0040});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule